// File: doc/BRIEF.md
# Bus Clock Prescaler Chain

This block takes one system clock and makes a set of single-cycle clock enables from it. A core-bus enable comes from a divider set by a 4-bit code. Two peripheral-bus enables are derived from that core-bus enable, each through its own divider set by a 3-bit code.

Each peripheral bus also has a timer enable. The timer enable pulses twice as often as its bus enable whenever that bus is divided. It equals the bus enable when the bus runs 1:1. A tick enable runs at one eighth of the core-bus rate, and a free-running core enable repeats the core-bus enable.

All codes, plus a two-bit clock source selector, are held in one 32-bit configuration word loaded through a plain write strobe. The selector is only passed to an output for the source switch outside this block. Every output is an enable in the input clock domain, not a generated clock. There is no data stream, so there is no valid/ready handshake.

Top module: `bus_clk_prescaler`

## Requirements
- R1: After reset every code is 0. `core_en`, `core_free_en`, `pb1_en`, `pb1_tmr_en`, `pb2_en` and `pb2_tmr_en` are high on every cycle, `tick_en` pulses once every 8 cycles, and `src_sel` is 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` at the clock edge. `src_sel` then shows bits [1:0] (0 internal oscillator, 1 external oscillator, 2 PLL, 3 passed through as written). Bits [31:16], [9:8] and [3:2] have no effect on any output.
- R3: The core code sits in bits [7:4]. Codes 0..7 give divide by 1. Codes 8, 9, 10 and 11 give 2, 4, 8 and 16. Codes 12, 13, 14 and 15 give 64, 128, 256 and 512. Divide by 32 cannot be selected.
- R4: Peripheral 1 takes its code from bits [12:10] and peripheral 2 from bits [15:13]. Codes 0..3 divide the core-bus enable by 1, and codes 4, 5, 6 and 7 divide it by 2, 4, 8 and 16. A peripheral enable is high only in a cycle where `core_en` is high.
- R5: With its code at 4 or more, a peripheral's timer enable pulses twice as often as its bus enable. With a code of 0..3 it equals the bus enable. A bus pulse always coincides with a timer pulse.
- R6: `tick_en` pulses once per 8 `core_en` pulses and only with `core_en`. `core_free_en` equals `core_en` on every cycle.
- R7: A new code takes effect only at the last pulse of the division period already in progress. No gap between two pulses of any divided enable is ever shorter than either the old or the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| src_sel | output | 2 | Clock source selector from bits [1:0] |
| core_en | output | 1 | Core-bus enable |
| core_free_en | output | 1 | Free-running core enable, equal to core_en |
| tick_en | output | 1 | Core-bus rate divided by 8 |
| pb1_en | output | 1 | Peripheral bus 1 enable |
| pb1_tmr_en | output | 1 | Peripheral bus 1 timer enable |
| pb2_en | output | 1 | Peripheral bus 2 enable |
| pb2_tmr_en | output | 1 | Peripheral bus 2 timer enable |

## Verification
The bench builds the block with its default parameters. These are a 9-bit core counter, 4-bit peripheral counters and a 3-bit tick divider, so every core code up to divide by 512 and every peripheral code up to divide by 16 can be reached. Pulse counts are taken over windows that are whole multiples of the longest period in use, which makes each expected count exact whatever the starting phase. The slowest combination, 512 times 16, still fits inside a window of about sixteen thousand cycles. A directed test changes the core code in the middle of a divide-by-512 period and measures the gaps on each side of the switch.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam int CORE_CODE_W = 4;
  localparam int PB_CODE_W   = 3;
  localparam int SRC_LSB     = 0;
  localparam int CORE_LSB    = 4;
  localparam int PB1_LSB     = 10;
  localparam int PB2_LSB     = 13;
  localparam int NUM_PB      = 2;

  // log2 of the core-bus ratio; the step from 16 to 64 skips ratio 32
  function automatic logic [3:0] core_log2(input logic [CORE_CODE_W-1:0] code);
    if (!code[3])        return 4'd0;
    else if (!code[2])   return 4'(code[1:0]) + 4'd1;
    else                 return 4'(code[1:0]) + 4'd6;
  endfunction

  function automatic logic [2:0] pb_log2(input logic [PB_CODE_W-1:0] code);
    if (!code[2]) return 3'd0;
    else          return 3'(code[1:0]) + 3'd1;
  endfunction
endpackage

// File: rtl/bcp_pow2_div.sv
module bcp_pow2_div #(
  parameter int MAX_LOG = 9,
  localparam int LOG_W = $clog2(MAX_LOG + 1),
  localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [LOG_W-1:0] log_req,
  output logic             div_en,
  output logic             half_en
);
  logic [LOG_W-1:0] act_log;
  logic [CNT_W-1:0] cnt, mask, half_mask;
  logic             wrap, half_hit;

  assign mask      = CNT_W'((CNT_W + 1)'(1) << act_log) - CNT_W'(1);
  assign half_mask = mask >> 1;
  assign wrap      = (cnt == mask);
  assign half_hit  = (act_log == '0) ? wrap : ((cnt & half_mask) == half_mask);
  assign div_en    = in_en & wrap;
  assign half_en   = in_en & half_hit;

  // the requested ratio is adopted only at a rollover
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_log <= '0;
    end else if (in_en) begin
      if (wrap) begin
        cnt     <= '0;
        act_log <= log_req;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= mask); // R7
  AST_RATIO_AT_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (act_log != $past(act_log)) |-> $past(div_en)); // R7
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
  import bcp_pkg::*;
#(
  parameter int CFG_W        = 32,
  parameter int CORE_LOG_MAX = 9,
  parameter int PB_LOG_MAX   = 4,
  parameter int TICK_LOG     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [1:0]       src_sel,
  output logic             core_en,
  output logic             core_free_en,
  output logic             tick_en,
  output logic             pb1_en,
  output logic             pb1_tmr_en,
  output logic             pb2_en,
  output logic             pb2_tmr_en
);
  localparam int CORE_LW = $clog2(CORE_LOG_MAX + 1);
  localparam int PB_LW   = $clog2(PB_LOG_MAX + 1);
  localparam int TICK_LW = $clog2(TICK_LOG + 1);

  logic [1:0]             src_q;
  logic [CORE_CODE_W-1:0] core_code_q;
  logic [PB_CODE_W-1:0]   pb_code_q [NUM_PB];
  logic [NUM_PB-1:0]      pb_en, pb_tmr;
  logic                   unused_core_half, unused_tick_half;
  logic                   unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:16], cfg_wdata[9:8], cfg_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= '0;
      core_code_q <= '0;
      pb_code_q   <= '{default: '0};
    end else if (cfg_we) begin
      src_q        <= cfg_wdata[SRC_LSB +: 2];
      core_code_q  <= cfg_wdata[CORE_LSB +: CORE_CODE_W];
      pb_code_q[0] <= cfg_wdata[PB1_LSB +: PB_CODE_W];
      pb_code_q[1] <= cfg_wdata[PB2_LSB +: PB_CODE_W];
    end
  end

  assign src_sel = src_q;

  bcp_pow2_div #(.MAX_LOG(CORE_LOG_MAX)) u_core (
    .clk(clk), .rst_n(rst_n), .in_en(1'b1),
    .log_req(CORE_LW'(core_log2(core_code_q))),
    .div_en(core_en), .half_en(unused_core_half)
  );

  bcp_pow2_div #(.MAX_LOG(TICK_LOG)) u_tick (
    .clk(clk), .rst_n(rst_n), .in_en(core_en),
    .log_req(TICK_LW'(TICK_LOG)),
    .div_en(tick_en), .half_en(unused_tick_half)
  );

  for (genvar g = 0; g < NUM_PB; g++) begin : g_pb
    bcp_pow2_div #(.MAX_LOG(PB_LOG_MAX)) u_pb (
      .clk(clk), .rst_n(rst_n), .in_en(core_en),
      .log_req(PB_LW'(pb_log2(pb_code_q[g]))),
      .div_en(pb_en[g]), .half_en(pb_tmr[g])
    );
    AST_PB_UNDER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      pb_en[g] |-> core_en); // R4
    AST_TMR_WITH_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      pb_en[g] |-> pb_tmr[g]); // R5
  end

  assign core_free_en = core_en;
  assign pb1_en       = pb_en[0];
  assign pb1_tmr_en   = pb_tmr[0];
  assign pb2_en       = pb_en[1];
  assign pb2_tmr_en   = pb_tmr[1];

  AST_TICK_UNDER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |-> core_en); // R6
  AST_SRC_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (src_sel == $past(cfg_wdata[1:0]))); // R2
endmodule

// File: tb/sim_bus_clk_prescaler.sv
`timescale 1ns/1ps
module sim_bus_clk_prescaler;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0] src_sel;
  logic core_en, core_free_en, tick_en, pb1_en, pb1_tmr_en, pb2_en, pb2_tmr_en;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_clk_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .src_sel(src_sel), .core_en(core_en), .core_free_en(core_free_en),
    .tick_en(tick_en), .pb1_en(pb1_en), .pb1_tmr_en(pb1_tmr_en),
    .pb2_en(pb2_en), .pb2_tmr_en(pb2_tmr_en)
  );

  // words: [15:13] pb2, [12:10] pb1, [7:4] core, [1:0] src, other bits filler
  localparam logic [31:0] VEC [8] = '{
    32'h0000_0000, 32'hFFFF_B38D, 32'h0000_7C72, 32'h1234_C0B8,
    32'h0000_94C1, 32'hA5A5_FCF2, 32'h0000_8C93, 32'h0000_18D0
  };

  function automatic int exp_core(input logic [3:0] c);
    case (c)
      4'd8: return 2;   4'd9: return 4;   4'd10: return 8;  4'd11: return 16;
      4'd12: return 64; 4'd13: return 128; 4'd14: return 256; 4'd15: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_pb(input logic [2:0] c);
    case (c)
      3'd4: return 2; 3'd5: return 4; 3'd6: return 8; 3'd7: return 16;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  int n_core, n_free_bad, n_tick, n_p1, n_t1, n_p2, n_t2, n_orphan;
  task automatic count_window(input int w);
    n_core = 0; n_free_bad = 0; n_tick = 0; n_p1 = 0; n_t1 = 0;
    n_p2 = 0; n_t2 = 0; n_orphan = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      n_core += int'(core_en);  n_tick += int'(tick_en);
      n_p1 += int'(pb1_en);     n_t1 += int'(pb1_tmr_en);
      n_p2 += int'(pb2_en);     n_t2 += int'(pb2_tmr_en);
      if (core_free_en != core_en) n_free_bad++;
      if ((pb1_en || pb2_en || tick_en) && !core_en) n_orphan++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int prev_p, gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_en && pb1_en && pb1_tmr_en && pb2_en && pb2_tmr_en && core_free_en,
        "R1 enables high", int'(core_en), 1);
    chk(src_sel == 2'd0, "R1 src_sel", int'(src_sel), 0);
    count_window(64);
    chk(n_tick == 8, "R1 tick count", n_tick, 8);
    chk(n_p1 == 64 && n_t2 == 64, "R1 pb count", n_p1, 64);

    prev_p = 8;
    foreach (VEC[k]) begin
      int cd, d1, d2, mx, w;
      cd = exp_core(VEC[k][7:4]);
      d1 = exp_pb(VEC[k][12:10]);
      d2 = exp_pb(VEC[k][15:13]);
      mx = (d1 > d2) ? d1 : d2;
      if (mx < 8) mx = 8;
      write_cfg(VEC[k]);
      chk(src_sel == VEC[k][1:0], "R2 src_sel", int'(src_sel), int'(VEC[k][1:0]));
      repeat (2 * (prev_p + cd * mx) + 4) @(negedge clk);
      w = cd * mx * 2;
      count_window(w);
      chk(n_core == w / cd, "R3 core ratio", n_core, w / cd);
      chk(n_p1 == w / (cd * d1), "R4 pb1 ratio", n_p1, w / (cd * d1));
      chk(n_p2 == w / (cd * d2), "R4 pb2 ratio", n_p2, w / (cd * d2));
      chk(n_orphan == 0, "R4 R6 pulse outside core_en", n_orphan, 0);
      chk(n_t1 == ((d1 == 1) ? n_p1 : 2 * n_p1), "R5 tmr1", n_t1, (d1 == 1) ? n_p1 : 2 * n_p1);
      chk(n_t2 == ((d2 == 1) ? n_p2 : 2 * n_p2), "R5 tmr2", n_t2, (d2 == 1) ? n_p2 : 2 * n_p2);
      chk(n_tick == w / (cd * 8), "R6 tick ratio", n_tick, w / (cd * 8));
      chk(n_free_bad == 0, "R6 core_free_en", n_free_bad, 0);
      prev_p = cd * mx;
    end

    // R7: switch core from /512 to /2 in the middle of a period
    write_cfg(32'h0000_00F0);
    repeat (2 * (prev_p + 512 * 8) + 4) @(negedge clk);
    while (!core_en) @(negedge clk);
    repeat (100) @(negedge clk);
    write_cfg(32'h0000_0080);
    gap = 102;
    do begin @(negedge clk); gap++; end while (!core_en);
    chk(gap == 512, "R7 old period completes", gap, 512);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!core_en);
    chk(gap == 2, "R7 new ratio after rollover", gap, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule